// File: doc/BRIEF.md
# Clock Divisor Transition Sequencer

This block moves a core clock divider from its present ratio to a requested one. It also orders the memory-controller updates around each change so that DRAM refresh stays safe throughout. A requester presents a 3-bit ratio index with a one-cycle valid. The sequencer then emits a series of single-cycle load strobes. Each strobe carries a new divider select code, a new self-refresh enable level, or a new 7-bit refresh count. The sequencer holds each value on its output until the next strobe of the same kind.

There are five divide ratios. A change between ratio 1 and any ratio above 2 runs as two legs through ratio 2. The steps of each leg follow an order that depends on the direction of the change. A fixed PLL-lock pause follows every divider write. A refresh-drain pause may follow a refresh-count load. The drain lasts long enough for both the old count and the new count to run out. The refresh count for each ratio is fixed at elaboration from the input clock frequency parameter, so the block has no divider circuit at run time. Reset leaves the block at ratio 1 with self-refresh off.

Top module: `clkdiv_seq`

## Requirements
- R1: After reset the block is idle. `divCode` is 000 and `srEn` is 0. `refCount` holds the count for ratio 1. `busy`, `done`, `err` and all three load strobes are 0.
- R2: Index 0..4 selects ratio 1, 2, 4, 6, 8. The code driven on `divCode` for these ratios is 000, 001, 011, 010 and 100 in that order.
- R3: The count loaded for ratio r is floor(CLK_HZ × 7800 / (64 × r × 10^9)), limited to 127. With the default CLK_HZ of 400 MHz this gives 48, 24, 12, 8 and 6.
- R4: A leg from ratio 2 to ratio 1 clears `srEn`. The divider write follows one cycle later. The lock pause comes next, and the refresh count is loaded last.
- R5: A leg from ratio 1 to ratio 2 loads the refresh count first. It then drains if `srEn` is 0, writes the divider, pauses for lock, and finally sets `srEn`.
- R6: Any other leg to a larger ratio loads the refresh count. The divider write follows one cycle later, and a lock pause follows that.
- R7: Any other leg to a smaller ratio writes the divider and pauses for lock. It then loads the refresh count, followed by a drain if `srEn` is 0.
- R8: After each `divLoad` pulse, no load strobe of any kind appears for LOCK_CYCLES cycles (default 16). The next strobe comes LOCK_CYCLES+1 cycles after the divider strobe.
- R9: When a drain applies, the strobe after `refLoad` comes D+1 cycles later. D = 64 × (old count + new count) × old ratio. With no drain, the next strobe comes one cycle after `refLoad`.
- R10: A change between ratio 1 and a ratio above 2 runs as two legs. The first leg goes to ratio 2, and the second goes from ratio 2 to the target. No single divider write spans that gap.
- R11: A request for the ratio already in use pulses `done` on the next cycle. `busy` stays low, and no strobe appears.
- R12: A request with index 5, 6 or 7 pulses `err` on the next cycle. No strobe appears, and every output value is left as it was.
- R13: `busy` rises the cycle after an accepted request and stays high to the end of the last leg. `done` pulses for one cycle in the first cycle with `busy` low. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, the undivided input clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle request strobe |
| reqIdx | input | 3 | Requested ratio index |
| busy | output | 1 | A transition is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | One-cycle pulse when a request has an illegal index |
| divCode | output | 3 | Divider select code |
| divLoad | output | 1 | Strobe: load `divCode` into the divider |
| srEn | output | 1 | Self-refresh enable level |
| srLoad | output | 1 | Strobe: load `srEn` into the memory controller |
| refCount | output | 7 | Refresh count value |
| refLoad | output | 1 | Strobe: load `refCount` into the memory controller |

## Verification
An accepted request raises `busy` one cycle later. Each step's strobe appears one cycle after the control state that issues it. A lock pause puts LOCK_CYCLES quiet cycles after `divLoad`, and a drain puts D quiet cycles after `refLoad`. `done` or `err` appears exactly one cycle after the request that ends the transition or is refused. The bench works these rules out into a queue of expected per-cycle output vectors and compares the whole output set on every falling edge. This puts the exact cycle of each strobe under check, not just the order of the strobes.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int NUM_RATIOS = 5;
  localparam int IDX_W      = 3;
  localparam int CODE_W     = 3;
  localparam int CNT_W      = 7;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int MAX_IDX    = NUM_RATIOS - 1;
  localparam int CLKS_PER_CNT_LOG2 = 6;
  localparam int MAX_RATIO  = 8;
  localparam int MAX_DRAIN  = (1 << CLKS_PER_CNT_LOG2) * 2 * CNT_MAX * MAX_RATIO;
  localparam int WAIT_W     = $clog2(MAX_DRAIN + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_LEG, S_SRCLR, S_SRSET, S_DIV, S_LOCK, S_CNT, S_DRAIN, S_END
  } seqState_t;

  typedef enum logic [1:0] {
    LEG_TWO_TO_ONE, LEG_ONE_TO_TWO, LEG_SLOWER, LEG_FASTER
  } legKind_t;

  typedef struct packed {
    logic             srClr;
    logic             srSet;
    logic             divWr;
    logic             cntWr;
    logic             drainLoad;
    logic             waitRun;
    logic [IDX_W-1:0] legFrom;
    logic [IDX_W-1:0] legTo;
  } seqStrobes_t;

  function automatic logic [3:0] ratioOf(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] codeOf(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return 3'b000;
      3'd1:    return 3'b001;
      3'd2:    return 3'b011;
      3'd3:    return 3'b010;
      3'd4:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] refCountFor(input longint unsigned hz,
                                                   input int ratio);
    longint unsigned num;
    longint unsigned den;
    longint unsigned q;
    if (ratio <= 0) return '0;
    num = hz * 64'd7800;
    den = 64'd64 * longint'(ratio) * 64'd1000000000;
    q   = num / den;
    if (q > longint'(CNT_MAX)) q = longint'(CNT_MAX);
    return CNT_W'(q);
  endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [IDX_W-1:0] curIdx,
  input  logic             srEn,
  input  logic             waitZero,
  input  logic             drainNone,
  output seqStrobes_t      ctl,
  output logic             busy,
  output logic             done,
  output logic             err
);

  seqState_t        stateQ, stateD;
  legKind_t         kindQ, kindCalc;
  logic [IDX_W-1:0] tgtQ, legFromQ, legToQ, legToCalc;
  logic             doneQ, errQ;
  logic             reqLegal, reqSame, drainGo, lastLeg;

  assign reqLegal = reqIdx <= IDX_W'(MAX_IDX);
  assign reqSame  = reqIdx == curIdx;
  assign lastLeg  = legToQ == tgtQ;

  // Leg planning: go through ratio 2 when jumping between 1 and >2
  always_comb begin
    if ((curIdx == 3'd0 && tgtQ > 3'd1) || (curIdx > 3'd1 && tgtQ == 3'd0))
      legToCalc = 3'd1;
    else
      legToCalc = tgtQ;
    if (curIdx == 3'd1 && legToCalc == 3'd0)
      kindCalc = LEG_TWO_TO_ONE;
    else if (curIdx == 3'd0 && legToCalc == 3'd1)
      kindCalc = LEG_ONE_TO_TWO;
    else if (legToCalc > curIdx)
      kindCalc = LEG_SLOWER;
    else
      kindCalc = LEG_FASTER;
  end

  assign drainGo = (kindQ == LEG_ONE_TO_TWO || kindQ == LEG_FASTER) && !srEn && !drainNone;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      S_IDLE:
        if (reqValid && reqLegal && !reqSame) stateD = S_LEG;
      S_LEG:
        case (kindCalc)
          LEG_TWO_TO_ONE: stateD = S_SRCLR;
          LEG_ONE_TO_TWO: stateD = S_CNT;
          LEG_SLOWER:     stateD = S_CNT;
          default:        stateD = S_DIV;
        endcase
      S_SRCLR: stateD = S_DIV;
      S_DIV:   stateD = S_LOCK;
      S_LOCK:
        if (waitZero) begin
          case (kindQ)
            LEG_TWO_TO_ONE: stateD = S_CNT;
            LEG_ONE_TO_TWO: stateD = S_SRSET;
            LEG_SLOWER:     stateD = S_END;
            default:        stateD = S_CNT;
          endcase
        end
      S_CNT:
        if (drainGo)
          stateD = S_DRAIN;
        else if (kindQ == LEG_ONE_TO_TWO || kindQ == LEG_SLOWER)
          stateD = S_DIV;
        else
          stateD = S_END;
      S_DRAIN:
        if (waitZero) stateD = (kindQ == LEG_ONE_TO_TWO) ? S_DIV : S_END;
      S_SRSET: stateD = S_END;
      S_END:   stateD = lastLeg ? S_IDLE : S_LEG;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      kindQ    <= LEG_SLOWER;
      tgtQ     <= '0;
      legFromQ <= '0;
      legToQ   <= '0;
      doneQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= (stateQ == S_IDLE && reqValid && reqLegal && reqSame) ||
                (stateQ == S_END && lastLeg);
      errQ   <= stateQ == S_IDLE && reqValid && !reqLegal;
      if (stateQ == S_IDLE && reqValid && reqLegal) tgtQ <= reqIdx;
      if (stateQ == S_LEG) begin
        kindQ    <= kindCalc;
        legFromQ <= curIdx;
        legToQ   <= legToCalc;
      end
    end
  end

  always_comb begin
    ctl.srClr     = stateQ == S_SRCLR;
    ctl.srSet     = stateQ == S_SRSET;
    ctl.divWr     = stateQ == S_DIV;
    ctl.cntWr     = stateQ == S_CNT;
    ctl.drainLoad = stateQ == S_CNT && drainGo;
    ctl.waitRun   = stateQ == S_LOCK || stateQ == S_DRAIN;
    ctl.legFrom   = legFromQ;
    ctl.legTo     = legToQ;
  end

  assign busy = stateQ != S_IDLE;
  assign done = doneQ;
  assign err  = errQ;

  // R10: no divider write may span ratio 1 and a ratio above 2
  a_r10_no_direct_jump: assert property (@(posedge clk) disable iff (!rstN)
    ctl.divWr |-> !((legFromQ == 3'd0 && legToQ > 3'd1) || (legFromQ > 3'd1 && legToQ == 3'd0)));

  // R11: same-ratio request completes without entering a transition
  a_r11_same_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_IDLE && reqValid && reqIdx == curIdx) |=> (!busy && done));

  // R12: an illegal index never starts a transition
  a_r12_err_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busy);

  // R13: completion pulse only once busy is gone, and lasts one cycle
  a_r13_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r13_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/clkdiv_dpath.sv
module clkdiv_dpath
  import clkdiv_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 64'd400_000_000,
  parameter int              LOCK_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       ctl,
  output logic [IDX_W-1:0]  curIdx,
  output logic              waitZero,
  output logic              drainNone,
  output logic [CODE_W-1:0] divCode,
  output logic              divLoad,
  output logic              srEn,
  output logic              srLoad,
  output logic [CNT_W-1:0]  refCount,
  output logic              refLoad
);

  localparam int TAB_N = 1 << IDX_W;
  localparam int AGE_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [WAIT_W-1:0] LOCK_RELOAD = WAIT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0]  cntTab [TAB_N];
  logic [IDX_W-1:0]  curIdxQ;
  logic [CODE_W-1:0] divCodeQ;
  logic              divLoadQ, srEnQ, srLoadQ, refLoadQ;
  logic [CNT_W-1:0]  refCountQ;
  logic [WAIT_W-1:0] waitQ, drainLen;
  logic [CNT_W:0]    sumCnt;
  logic [11:0]       prodCnt;
  logic [CNT_W-1:0]  newCnt;

  // Per-ratio refresh counts fixed at elaboration
  for (genvar g = 0; g < TAB_N; g++) begin : g_tab
    if (g < NUM_RATIOS) begin : g_used
      assign cntTab[g] = refCountFor(CLK_HZ, int'(ratioOf(IDX_W'(g))));
    end else begin : g_unused
      assign cntTab[g] = '0;
    end
  end

  assign newCnt   = cntTab[ctl.legTo];
  assign sumCnt   = {1'b0, refCountQ} + {1'b0, newCnt};
  assign prodCnt  = 12'(sumCnt) * 12'(ratioOf(ctl.legFrom));
  assign drainLen = WAIT_W'({prodCnt, {CLKS_PER_CNT_LOG2{1'b0}}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdxQ   <= '0;
      divCodeQ  <= codeOf(3'd0);
      divLoadQ  <= 1'b0;
      srEnQ     <= 1'b0;
      srLoadQ   <= 1'b0;
      refCountQ <= cntTab[0];
      refLoadQ  <= 1'b0;
      waitQ     <= '0;
    end else begin
      divLoadQ <= ctl.divWr;
      srLoadQ  <= ctl.srClr || ctl.srSet;
      refLoadQ <= ctl.cntWr;
      if (ctl.divWr) begin
        curIdxQ  <= ctl.legTo;
        divCodeQ <= codeOf(ctl.legTo);
      end
      if (ctl.srClr) srEnQ <= 1'b0;
      else if (ctl.srSet) srEnQ <= 1'b1;
      if (ctl.cntWr) refCountQ <= newCnt;
      if (ctl.divWr)
        waitQ <= LOCK_RELOAD;
      else if (ctl.drainLoad)
        waitQ <= drainLen - WAIT_W'(1);
      else if (ctl.waitRun && waitQ != '0)
        waitQ <= waitQ - WAIT_W'(1);
    end
  end

  assign curIdx    = curIdxQ;
  assign waitZero  = waitQ == '0;
  assign drainNone = drainLen == '0;
  assign divCode   = divCodeQ;
  assign divLoad   = divLoadQ;
  assign srEn      = srEnQ;
  assign srLoad    = srLoadQ;
  assign refCount  = refCountQ;
  assign refLoad   = refLoadQ;

  // Checker state: cycles since the last divider strobe, saturating
  logic [AGE_W-1:0] ageQ;
  always_ff @(posedge clk) begin
    if (!rstN) ageQ <= AGE_W'(LOCK_CYCLES);
    else if (divLoadQ) ageQ <= AGE_W'(1);
    else if (ageQ < AGE_W'(LOCK_CYCLES)) ageQ <= ageQ + AGE_W'(1);
  end

  // R8: PLL lock window free of any further strobe
  a_r8_lock_gap: assert property (@(posedge clk) disable iff (!rstN)
    (divLoadQ || srLoadQ || refLoadQ) |-> ageQ >= AGE_W'(LOCK_CYCLES));

  // R2: only the five legal divider codes ever appear
  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    divCode inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b100});

  // R4/R5: self-refresh only changes while the divider sits at ratio 2
  a_r5_sr_at_two: assert property (@(posedge clk) disable iff (!rstN)
    srLoadQ |-> divCode == 3'b001);

  // R6: one kind of strobe per cycle
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({divLoadQ, srLoadQ, refLoadQ}));

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 64'd400_000_000,
  parameter int              LOCK_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqIdx,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       divCode,
  output logic             divLoad,
  output logic             srEn,
  output logic             srLoad,
  output logic [6:0]       refCount,
  output logic             refLoad
);

  seqStrobes_t      ctl;
  logic [IDX_W-1:0] curIdx;
  logic             waitZero, drainNone;

  clkdiv_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqIdx    (reqIdx),
    .curIdx    (curIdx),
    .srEn      (srEn),
    .waitZero  (waitZero),
    .drainNone (drainNone),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  clkdiv_dpath #(
    .CLK_HZ      (CLK_HZ),
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .curIdx    (curIdx),
    .waitZero  (waitZero),
    .drainNone (drainNone),
    .divCode   (divCode),
    .divLoad   (divLoad),
    .srEn      (srEn),
    .srLoad    (srLoad),
    .refCount  (refCount),
    .refLoad   (refLoad)
  );

endmodule

// File: tb/tb_clkdiv_seq.sv
module tb_clkdiv_seq;

  localparam longint unsigned CLK_HZ = 64'd400_000_000;
  localparam int LOCK = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqIdx = 3'd0;
  logic busy, done, err, divLoad, srEn, srLoad, refLoad;
  logic [2:0] divCode;
  logic [6:0] refCount;

  always #2.5 clk = ~clk;

  clkdiv_seq #(.CLK_HZ(CLK_HZ), .LOCK_CYCLES(LOCK)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIdx(reqIdx),
    .busy(busy), .done(done), .err(err), .divCode(divCode), .divLoad(divLoad),
    .srEn(srEn), .srLoad(srLoad), .refCount(refCount), .refLoad(refLoad)
  );

  typedef struct packed {
    logic busy, done, err, divLoad, srEn, srLoad, refLoad;
    logic [2:0] divCode;
    logic [6:0] refCount;
  } rec_t;

  rec_t  expQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string curReq = "R1";

  int   mCur = 0;
  logic mSr = 1'b0;
  int   mCnt;
  logic [2:0] mCode = 3'b000;

  function automatic int ratioB(int i);
    int r [5] = '{1, 2, 4, 6, 8};
    return r[i];
  endfunction

  function automatic logic [2:0] codeB(int i);
    logic [2:0] c [5] = '{3'b000, 3'b001, 3'b011, 3'b010, 3'b100};
    return c[i];
  endfunction

  function automatic int cntB(int i);
    longint unsigned v;
    v = (CLK_HZ * 64'd7800) / (64'd64 * longint'(ratioB(i)) * 64'd1000000000);
    if (v > 127) v = 127;
    return int'(v);
  endfunction

  function automatic rec_t mk(logic b, logic d, logic e, logic dl, logic sl, logic rl);
    rec_t r;
    r.busy = b; r.done = d; r.err = e; r.divLoad = dl; r.srLoad = sl; r.refLoad = rl;
    r.srEn = mSr; r.divCode = mCode; r.refCount = 7'(mCnt);
    return r;
  endfunction

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) expQ.push_back(mk(1, 0, 0, 0, 0, 0));
  endtask

  task automatic divW(int idx);
    mCode = codeB(idx); mCur = idx;
    expQ.push_back(mk(1, 0, 0, 1, 0, 0));
    quiet(LOCK);                          // R8 lock pause
  endtask

  task automatic srW(logic v);
    mSr = v;
    expQ.push_back(mk(1, 0, 0, 0, 1, 0));
  endtask

  task automatic cntW(int idx, int oldRatio, bit mayDrain);
    int oldC;
    oldC = mCnt; mCnt = cntB(idx);
    expQ.push_back(mk(1, 0, 0, 0, 0, 1));
    if (mayDrain && !mSr) quiet(64 * (oldC + mCnt) * oldRatio);  // R9 drain
  endtask

  // Behavioural model of one request, built from the requirement text
  task automatic modelReq(int t);
    int nxt, r0, r1;
    if (t > 4) begin
      expQ.push_back(mk(0, 0, 1, 0, 0, 0));
      return;
    end
    if (t == mCur) begin
      expQ.push_back(mk(0, 1, 0, 0, 0, 0));
      return;
    end
    quiet(1);
    while (mCur != t) begin
      quiet(1);
      r0 = ratioB(mCur);
      nxt = ((r0 == 1 && ratioB(t) > 2) || (r0 > 2 && t == 0)) ? 1 : t;
      r1 = ratioB(nxt);
      if (r0 == 2 && r1 == 1) begin
        srW(0); divW(nxt); cntW(nxt, r0, 0);
      end else if (r0 == 1 && r1 == 2) begin
        cntW(nxt, r0, 1); divW(nxt); srW(1);
      end else if (r1 > r0) begin
        cntW(nxt, r0, 0); divW(nxt);
      end else begin
        divW(nxt); cntW(nxt, r0, 1);
      end
      if (mCur == t) expQ.push_back(mk(0, 1, 0, 0, 0, 0));
      else quiet(1);
    end
  endtask

  task automatic cycle();
    rec_t e, a;
    @(negedge clk);
    e = (expQ.size() > 0) ? expQ.pop_front() : mk(0, 0, 0, 0, 0, 0);
    a.busy = busy; a.done = done; a.err = err; a.divLoad = divLoad; a.srEn = srEn;
    a.srLoad = srLoad; a.refLoad = refLoad; a.divCode = divCode; a.refCount = refCount;
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s t=%0t actual b%0b d%0b e%0b dl%0b code%03b sl%0b sr%0b rl%0b cnt%0d expected b%0b d%0b e%0b dl%0b code%03b sl%0b sr%0b rl%0b cnt%0d",
               curReq, $time, a.busy, a.done, a.err, a.divLoad, a.divCode, a.srLoad, a.srEn,
               a.refLoad, a.refCount, e.busy, e.done, e.err, e.divLoad, e.divCode, e.srLoad,
               e.srEn, e.refLoad, e.refCount);
    end
  endtask

  task automatic issue(int idx, string tag, int ignoreAt);
    curReq = tag;
    reqIdx = 3'(idx);
    reqValid = 1'b1;
    modelReq(idx);
    cycle();
    reqValid = 1'b0;
    for (int n = 1; expQ.size() > 0; n++) begin
      if (n == ignoreAt) begin
        reqIdx = 3'd4; reqValid = 1'b1;    // R13: ignored while busy
      end else begin
        reqValid = 1'b0;
      end
      cycle();
    end
    reqValid = 1'b0;
    cycle();
  endtask

  initial begin
    mCnt = cntB(0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1 R3 reset";
    cycle(); cycle();
    issue(1, "R5 R9 R2 R3 1->2", 0);
    issue(0, "R4 R8 2->1", 0);
    issue(3, "R10 R5 R6 1->6", 30);
    issue(2, "R7 R8 6->4", 0);
    issue(2, "R11 same ratio", 0);
    issue(5, "R12 index 5", 0);
    issue(7, "R12 index 7", 0);
    issue(0, "R10 R7 R4 4->1", 0);
    issue(4, "R10 R13 1->8 ignored req", 5000);
    issue(0, "R10 R7 R4 8->1", 10);
    issue(0, "R11 same ratio 1", 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired during %s", curReq);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule